// File: doc/BRIEF.md
# Prioritized UART Interrupt Identifier

This block collects every interrupt source of a 16550-style serial port and turns them into a single interrupt output plus an identification byte that the host reads. The sources are receive line errors, the receive FIFO fill level, a character-timeout strobe, the transmit holding register going empty, and modem input changes. Each source has its own enable bit. Only the most urgent enabled source that is pending is reported at any time. The block does not contain the FIFOs, shifters or bus decoder. It sits beside them and takes their status signals and register access strobes.

Receive data is not reported on every byte. It is reported once the receive FIFO count reaches a threshold picked by a two-bit trigger select. This condition is evaluated again every cycle from the live count, so the report clears as soon as the count drops below the threshold. Line errors, timeout, transmit-empty and modem changes are latched. Each one stays pending until its own clearing access occurs, whether or not its enable bit is set.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the identification byte is 0x01 and the interrupt output is low.
- R2: Bit 0 of the identification byte is 1 exactly when no enabled source is pending, and the interrupt output is always the inverse of that bit.
- R3: With the FIFO enabled and receive enable (enable bit 0) set, code 0100 in bits 3:0 is reported while the receive count is at or above the trigger level. Trigger select 00, 01, 10 and 11 give levels 1, 4, 8 and 14. The report disappears once the count falls below the level.
- R4: With the FIFO enabled, bits 7:6 of the identification byte read 11. With the FIFO disabled, they read 00 and the receive threshold is 1 byte.
- R5: Any pulse on the four line error inputs latches a pending line condition, reported as code 0110 when enable bit 2 is set. It clears only on a line-status read.
- R6: With the FIFO enabled, a timeout strobe latches a pending timeout, reported as code 1100 when enable bit 0 is set. It clears on a receive-data read.
- R7: A rising edge of the transmit-empty status latches a pending transmit interrupt, reported as code 0010 when enable bit 1 is set. It clears on an identification read made while 0010 is being reported, or on a transmit-data write.
- R8: Any pulse on the four modem change inputs latches a pending modem interrupt, reported as code 0000 when enable bit 3 is set. It clears on a modem-status read.
- R9: A disabled source is not reported but stays pending. Setting its enable bit later reports it without a new event.
- R10: A change of trigger select that brings the level to or below the current count reports code 0100 in the very next clock cycle.
- R11: When several enabled sources are pending, the order from highest to lowest is line (0110), receive data (0100), timeout (1100), transmit empty (0010), modem (0000). Bits 3:0 only ever hold one of these codes or 0001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | FIFO mode enable |
| trig_sel | input | 2 | Receive trigger level select |
| rx_count | input | CNT_W | Receive FIFO fill count |
| line_err | input | 4 | Line error event pulses (overrun, parity, framing, break) |
| char_tmo | input | 1 | Character timeout strobe |
| tx_empty | input | 1 | Transmit holding register empty status |
| modem_chg | input | 4 | Modem input change pulses |
| irq_en | input | 4 | Enables: 0 receive, 1 transmit empty, 2 line, 3 modem |
| rd_id | input | 1 | Identification register read strobe |
| rd_line | input | 1 | Line status read strobe |
| rd_modem | input | 1 | Modem status read strobe |
| rd_rxdata | input | 1 | Receive data read strobe |
| wr_txdata | input | 1 | Transmit data write strobe |
| irq | output | 1 | Interrupt output, registered |
| id_byte | output | 8 | Identification byte, registered |

## Verification
The hardest case to reach is a stack of several pending sources, where each clearing access must uncover exactly the next lower one. The transmit-empty source is the trickiest because it clears only on an identification read that is reporting it. The stimulus first latches modem and transmit-empty events while everything is masked. It then enables them, checks that 0010 wins, and issues an identification read. After that it expects 0000 to surface, and only then the idle code. Threshold changes are checked one cycle after a trigger-select write, so a lagging comparator would be caught.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  typedef enum logic [3:0] {
    ID_NONE    = 4'b0001,
    ID_LINE    = 4'b0110,
    ID_RXDATA  = 4'b0100,
    ID_TIMEOUT = 4'b1100,
    ID_TXEMPTY = 4'b0010,
    ID_MODEM   = 4'b0000
  } id_code_e;

  localparam int EN_RX    = 0;
  localparam int EN_TX    = 1;
  localparam int EN_LINE  = 2;
  localparam int EN_MODEM = 3;
  localparam int N_EN     = 4;
endpackage

// File: rtl/uart_irq_sticky.sv
module uart_irq_sticky #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_vec,
  input  logic         clr,
  output logic         pend
);
  // a new event in the clearing cycle wins, so it is never lost
  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else     pend <= (pend & ~clr) | (|set_vec);
  end
endmodule

// File: rtl/uart_irq_trigcmp.sv
module uart_irq_trigcmp #(
  parameter int CNT_W = 5,
  parameter int LVL0  = 1,
  parameter int LVL1  = 4,
  parameter int LVL2  = 8,
  parameter int LVL3  = 14
) (
  input  logic             fifo_en,
  input  logic [1:0]       trig_sel,
  input  logic [CNT_W-1:0] rx_count,
  output logic             at_level
);
  localparam logic [CNT_W-1:0] L0 = CNT_W'(LVL0);
  localparam logic [CNT_W-1:0] L1 = CNT_W'(LVL1);
  localparam logic [CNT_W-1:0] L2 = CNT_W'(LVL2);
  localparam logic [CNT_W-1:0] L3 = CNT_W'(LVL3);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] level;

  always_comb begin
    if (!fifo_en) level = ONE;
    else begin
      unique case (trig_sel)
        2'b00:   level = L0;
        2'b01:   level = L1;
        2'b10:   level = L2;
        default: level = L3;
      endcase
    end
    at_level = (rx_count >= level);
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic     line_act,
  input  logic     rx_act,
  input  logic     tmo_act,
  input  logic     tx_act,
  input  logic     modem_act,
  output id_code_e code
);
  always_comb begin
    if      (line_act)  code = ID_LINE;
    else if (rx_act)    code = ID_RXDATA;
    else if (tmo_act)   code = ID_TIMEOUT;
    else if (tx_act)    code = ID_TXEMPTY;
    else if (modem_act) code = ID_MODEM;
    else                code = ID_NONE;
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int TRIG0 = 1,
  parameter int TRIG1 = 4,
  parameter int TRIG2 = 8,
  parameter int TRIG3 = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_en,
  input  logic [1:0]       trig_sel,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [3:0]       line_err,
  input  logic             char_tmo,
  input  logic             tx_empty,
  input  logic [3:0]       modem_chg,
  input  logic [3:0]       irq_en,
  input  logic             rd_id,
  input  logic             rd_line,
  input  logic             rd_modem,
  input  logic             rd_rxdata,
  input  logic             wr_txdata,
  output logic             irq,
  output logic [7:0]       id_byte
);
  logic line_pend, modem_pend, tmo_pend, tx_pend;
  logic rx_at_level;
  logic tx_empty_q;
  logic tx_rise, tx_clr;
  id_code_e code;
  logic [7:0] id_next;

  // latched sources: line and modem share one sticky structure
  for (genvar g = 0; g < 2; g++) begin : g_sticky
    if (g == 0) begin : g_line
      uart_irq_sticky #(.W(4)) u_line (
        .clk(clk), .rst(rst), .set_vec(line_err), .clr(rd_line), .pend(line_pend));
    end else begin : g_modem
      uart_irq_sticky #(.W(4)) u_modem (
        .clk(clk), .rst(rst), .set_vec(modem_chg), .clr(rd_modem), .pend(modem_pend));
    end
  end

  uart_irq_sticky #(.W(1)) u_tmo (
    .clk(clk), .rst(rst), .set_vec(char_tmo & fifo_en), .clr(rd_rxdata), .pend(tmo_pend));

  always_ff @(posedge clk) begin
    if (rst) tx_empty_q <= 1'b0;
    else     tx_empty_q <= tx_empty;
  end

  assign tx_rise = tx_empty & ~tx_empty_q;
  assign tx_clr  = wr_txdata | (rd_id && (id_byte[3:0] == ID_TXEMPTY));

  uart_irq_sticky #(.W(1)) u_tx (
    .clk(clk), .rst(rst), .set_vec(tx_rise), .clr(tx_clr), .pend(tx_pend));

  uart_irq_trigcmp #(
    .CNT_W(CNT_W), .LVL0(TRIG0), .LVL1(TRIG1), .LVL2(TRIG2), .LVL3(TRIG3)
  ) u_cmp (
    .fifo_en(fifo_en), .trig_sel(trig_sel), .rx_count(rx_count), .at_level(rx_at_level));

  uart_irq_prio u_prio (
    .line_act (line_pend   & irq_en[EN_LINE]),
    .rx_act   (rx_at_level & irq_en[EN_RX]),
    .tmo_act  (tmo_pend    & irq_en[EN_RX]),
    .tx_act   (tx_pend     & irq_en[EN_TX]),
    .modem_act(modem_pend  & irq_en[EN_MODEM]),
    .code     (code));

  assign id_next = {{2{fifo_en}}, 2'b00, code};

  always_ff @(posedge clk) begin
    if (rst) begin
      id_byte <= 8'h01;
      irq     <= 1'b0;
    end else begin
      id_byte <= id_next;
      irq     <= ~id_next[0];
    end
  end
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk #(
  parameter int CNT_W    = 5,
  parameter int TRIG_MAX = 14
) (
  input logic             clk,
  input logic             rst,
  input logic             fifo_en,
  input logic [1:0]       trig_sel,
  input logic [CNT_W-1:0] rx_count,
  input logic [3:0]       irq_en,
  input logic             irq,
  input logic [7:0]       id_byte
);
  localparam logic [CNT_W-1:0] TMAX = CNT_W'(TRIG_MAX);

  assert_irq_pin_R2: assert property (@(posedge clk) disable iff (rst)
    irq == ~id_byte[0]);

  assert_fifo_id_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> id_byte[7:6] == {2{$past(fifo_en)}});

  assert_masked_R9: assert property (@(posedge clk) disable iff (rst)
    irq_en == 4'b0000 |=> id_byte[3:0] == 4'b0001);

  assert_rx_reach_R3: assert property (@(posedge clk) disable iff (rst)
    (fifo_en && irq_en == 4'b0001 && rx_count >= TMAX) |=> id_byte[3:0] == 4'b0100);

  assert_rx_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (fifo_en && trig_sel == 2'b11 && irq_en == 4'b0001 && rx_count < TMAX)
      |=> id_byte[3:0] != 4'b0100);

  assert_legal_code_R11: assert property (@(posedge clk) disable iff (rst)
    id_byte[3:0] == 4'b0001 || id_byte[3:0] == 4'b0110 || id_byte[3:0] == 4'b0100 ||
    id_byte[3:0] == 4'b1100 || id_byte[3:0] == 4'b0010 || id_byte[3:0] == 4'b0000);
endmodule

bind uart_irq_ident uart_irq_ident_chk #(.CNT_W(CNT_W), .TRIG_MAX(TRIG3)) u_chk (
  .clk(clk), .rst(rst), .fifo_en(fifo_en), .trig_sel(trig_sel), .rx_count(rx_count),
  .irq_en(irq_en), .irq(irq), .id_byte(id_byte));

// File: tb/uart_irq_ident_bench.sv
module uart_irq_ident_bench;
  localparam int CNT_W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fifo_en = 1'b0;
  logic [1:0] trig_sel = 2'b00;
  logic [CNT_W-1:0] rx_count = '0;
  logic [3:0] line_err = '0;
  logic char_tmo = 1'b0;
  logic tx_empty = 1'b0;
  logic [3:0] modem_chg = '0;
  logic [3:0] irq_en = '0;
  logic rd_id = 1'b0, rd_line = 1'b0, rd_modem = 1'b0, rd_rxdata = 1'b0, wr_txdata = 1'b0;
  logic irq;
  logic [7:0] id_byte;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  uart_irq_ident #(.CNT_W(CNT_W)) u_uart_irq_ident (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .trig_sel(trig_sel), .rx_count(rx_count),
    .line_err(line_err), .char_tmo(char_tmo), .tx_empty(tx_empty), .modem_chg(modem_chg),
    .irq_en(irq_en), .rd_id(rd_id), .rd_line(rd_line), .rd_modem(rd_modem),
    .rd_rxdata(rd_rxdata), .wr_txdata(wr_txdata), .irq(irq), .id_byte(id_byte));

  // monitor: pops expected items and compares away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() != 0) begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (id_byte !== e) begin
          fails++;
          $display("FAIL %s: id_byte actual %02h expected %02h", t, id_byte, e);
        end
        checks++;
        if (irq !== ~e[0]) begin
          fails++;
          $display("FAIL R2 (%s): irq actual %0b expected %0b", t, irq, ~e[0]);
        end
      end
    end
  end

  // driver side: wait n rising edges, then queue the expectation
  task automatic expect_id(input logic [7:0] e, input string t, input int n);
    repeat (n) @(posedge clk);
    exp_q.push_back(e);
    tag_q.push_back(t);
    wait (exp_q.size() == 0);
  endtask

  // which: 0 line err, 1 timeout, 2 modem chg, 3 rd_id, 4 rd_line, 5 rd_modem, 6 rd_rxdata, 7 wr_txdata
  task automatic strobe(input int which);
    @(negedge clk);
    case (which)
      0: line_err  = 4'b0100;
      1: char_tmo  = 1'b1;
      2: modem_chg = 4'b0001;
      3: rd_id     = 1'b1;
      4: rd_line   = 1'b1;
      5: rd_modem  = 1'b1;
      6: rd_rxdata = 1'b1;
      default: wr_txdata = 1'b1;
    endcase
    @(negedge clk);
    line_err = '0; char_tmo = 1'b0; modem_chg = '0;
    rd_id = 1'b0; rd_line = 1'b0; rd_modem = 1'b0; rd_rxdata = 1'b0; wr_txdata = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    expect_id(8'h01, "R1 reset value", 0);
    @(negedge clk) rst = 1'b0;
    expect_id(8'h01, "R1 idle after reset", 2);

    // R3 threshold per trigger select
    @(negedge clk) begin fifo_en = 1'b1; irq_en = 4'b0001; trig_sel = 2'b01; rx_count = 5'd3; end
    expect_id(8'hC1, "R3 count 3 below level 4", 3);
    @(negedge clk) rx_count = 5'd4;
    expect_id(8'hC4, "R3 count 4 reaches level 4", 3);
    @(negedge clk) rx_count = 5'd3;
    expect_id(8'hC1, "R3 falls below level clears", 3);
    @(negedge clk) begin trig_sel = 2'b11; rx_count = 5'd13; end
    expect_id(8'hC1, "R3 count 13 below level 14", 3);
    @(negedge clk) rx_count = 5'd14;
    expect_id(8'hC4, "R3 count 14 reaches level 14", 3);
    @(negedge clk) begin trig_sel = 2'b10; rx_count = 5'd7; end
    expect_id(8'hC1, "R3 count 7 below level 8", 3);
    @(negedge clk) rx_count = 5'd8;
    expect_id(8'hC4, "R3 count 8 reaches level 8", 3);
    @(negedge clk) begin trig_sel = 2'b00; rx_count = 5'd1; end
    expect_id(8'hC4, "R3 count 1 reaches level 1", 3);

    // R10 lowering trigger reports in the next cycle
    @(negedge clk) begin trig_sel = 2'b11; rx_count = 5'd5; end
    expect_id(8'hC1, "R10 count 5 below level 14", 3);
    @(negedge clk) trig_sel = 2'b01;
    expect_id(8'hC4, "R10 one cycle after trigger lowered", 1);

    // R4 non-FIFO mode
    @(negedge clk) begin fifo_en = 1'b0; trig_sel = 2'b11; rx_count = 5'd1; end
    expect_id(8'h04, "R4 non-FIFO single byte reports", 3);
    @(negedge clk) rx_count = 5'd0;
    expect_id(8'h01, "R4 non-FIFO empty idle", 3);

    // R5 and R11 line over receive data
    @(negedge clk) begin fifo_en = 1'b1; irq_en = 4'b1111; rx_count = 5'd14; end
    expect_id(8'hC4, "R11 rx data alone", 3);
    strobe(0);
    expect_id(8'hC6, "R5 line error wins over rx data", 3);
    strobe(3);
    expect_id(8'hC6, "R5 id read does not clear line", 3);
    strobe(4);
    expect_id(8'hC4, "R5 line read clears", 3);

    // R6 timeout
    @(negedge clk) rx_count = 5'd0;
    strobe(1);
    expect_id(8'hCC, "R6 timeout reported", 3);
    strobe(6);
    expect_id(8'hC1, "R6 rx data read clears timeout", 3);

    // R7 transmit empty
    @(negedge clk) tx_empty = 1'b1;
    expect_id(8'hC2, "R7 tx empty rise reported", 3);
    strobe(3);
    expect_id(8'hC1, "R7 id read reporting tx clears", 3);
    @(negedge clk) tx_empty = 1'b0;
    @(negedge clk) tx_empty = 1'b1;
    expect_id(8'hC2, "R7 second rise reported", 3);
    strobe(7);
    expect_id(8'hC1, "R7 tx write clears", 3);

    // R8 modem
    strobe(2);
    expect_id(8'hC0, "R8 modem change reported", 3);
    strobe(5);
    expect_id(8'hC1, "R8 modem read clears", 3);

    // R9 masked sources stay pending, then R11 ordering tx over modem
    @(negedge clk) begin irq_en = 4'b0000; tx_empty = 1'b0; end
    strobe(2);
    @(negedge clk) tx_empty = 1'b1;
    expect_id(8'hC1, "R9 masked sources not reported", 3);
    @(negedge clk) irq_en = 4'b1000;
    expect_id(8'hC0, "R9 enabling modem reports held event", 3);
    @(negedge clk) irq_en = 4'b1010;
    expect_id(8'hC2, "R11 tx empty over modem", 3);
    strobe(3);
    expect_id(8'hC0, "R11 modem surfaces after tx cleared", 3);
    strobe(3);
    expect_id(8'hC0, "R8 id read leaves modem pending", 3);
    strobe(5);
    expect_id(8'hC1, "R11 all cleared", 3);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule